// File: doc/BRIEF.md
# Capture FIFO DMA Request Generator

This block sits beside the write port of a video capture FIFO group and decides when a DMA engine should be asked to drain it. Every cycle in which a 64-bit doubleword enters the luma FIFO, an internal counter grows by one. When that count reaches the active threshold, the block emits a one-cycle event pulse. It then stays silent until the DMA engine makes its first read from the FIFO, which shows that servicing of the event has begun.

A single 32-bit control word holds two 10-bit thresholds, one per video field. In 8-bit YCbCr capture, the second-field value can replace the first-field value while field 2 is being captured. The block also gives the chroma FIFOs a threshold that is half the active luma threshold, and it keeps a sticky flag when an odd value makes that halving inexact. In the raw and plain byte-stream modes the first-field value is always used. Each doubleword then holds 8 samples in 8-bit modes and 4 samples in 16-bit raw mode. The counter restarts at every field boundary.

Top module: `capture_dma_req`

## Requirements
- R1: After reset the control word reads 0, `dma_evt` and `odd_err` are 0, and `thr_active` and `chroma_thr` are 0.
- R2: A write places `cfg_wdata[9:0]` in the field-1 threshold and `cfg_wdata[25:16]` in the field-2 threshold, and `cfg_rdata` shows them at the same positions from the cycle after the write. Bits 31:26 and 15:10 always read 0, and writing them has no effect.
- R3: `thr_active` is the field-2 threshold only when `mode` is 0 (8-bit YCbCr), `field` is 1 and `f2_en` is 1. In every other case it is the field-1 threshold. Mode codes: 0 YCbCr 8-bit, 1 raw 8-bit, 2 raw 16-bit, 3 byte stream.
- R4: When the count of `dw_wr` cycles reaches a nonzero `thr_active`, `dma_evt` goes high for exactly one cycle. It rises one clock after the edge that captured the doubleword which reached the threshold.
- R5: After an event, no further event is issued, whatever is written, until `dma_rd` is seen. A pending count at or above the threshold then produces the next event one cycle after the read edge.
- R6: An event subtracts the threshold from the count, so doublewords written while events are blocked still count toward later events.
- R7: A `thr_active` of 0 never produces an event.
- R8: `field_start` sets the count to 0, or to 1 if `dw_wr` is high in the same cycle.
- R9: `chroma_thr` is `thr_active` halved and rounded down in mode 0, and 0 in all other modes.
- R10: `odd_err` goes to 1 one cycle after an odd `thr_active` is seen in mode 0, and then stays at 1 until reset.
- R11: The count saturates at 2^12-1 (4095) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| mode | input | 2 | Capture mode code |
| field | input | 1 | Current field: 0 first, 1 second |
| f2_en | input | 1 | Allows the field-2 threshold to be used |
| field_start | input | 1 | Pulse at the start of each field |
| dw_wr | input | 1 | One doubleword written into the FIFO this cycle |
| dma_rd | input | 1 | DMA read from the FIFO this cycle |
| dma_evt | output | 1 | DMA event request pulse |
| thr_active | output | 10 | Threshold in force |
| chroma_thr | output | 10 | Threshold for the Cb and Cr FIFOs |
| odd_err | output | 1 | Sticky flag for an odd threshold in YCbCr mode |

## Verification
The control word, `thr_active` and `chroma_thr` settle in the cycle after the write edge, so the bench reads them at the next falling edge. `dma_evt` comes two edges after the edge that counted the threshold-reaching doubleword, or two edges after a re-arming read, and `odd_err` comes one edge after the odd threshold appears. The bench checks the exact event cycle once. Elsewhere it counts pulses over idle windows long enough to cover that latency, so an early, late or repeated pulse changes the count.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

    typedef enum logic [1:0] {
        MODE_YC8    = 2'd0,
        MODE_RAW8   = 2'd1,
        MODE_RAW16  = 2'd2,
        MODE_BYTE8  = 2'd3
    } cap_mode_e;

    localparam int CFG_W = 32;

endpackage

// File: rtl/cdr_thr_regs.sv
module cdr_thr_regs
    import cdr_pkg::*;
#(
    parameter int THR_W  = 10,
    parameter int F2_LSB = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [1:0]         mode,
    input  logic               field,
    input  logic               f2_en,
    output logic [CFG_W-1:0]   cfg_rdata,
    output logic [THR_W-1:0]   thr_active,
    output logic [THR_W-1:0]   chroma_thr,
    output logic               odd_err
);

    typedef struct packed {
        logic [THR_W-1:0] f1;
        logic [THR_W-1:0] f2;
        logic             err;
    } thr_state_t;

    thr_state_t state_d, state_q;
    logic       yc_mode;
    logic       use_f2;

    always_comb begin
        state_d    = state_q;
        yc_mode    = (mode == MODE_YC8);
        use_f2     = yc_mode && field && f2_en;
        thr_active = use_f2 ? state_q.f2 : state_q.f1;
        chroma_thr = yc_mode ? (thr_active >> 1) : '0;

        cfg_rdata                       = '0;
        cfg_rdata[THR_W-1:0]            = state_q.f1;
        cfg_rdata[F2_LSB +: THR_W]      = state_q.f2;

        if (cfg_wr) begin
            state_d.f1 = cfg_wdata[THR_W-1:0];
            state_d.f2 = cfg_wdata[F2_LSB +: THR_W];
        end
        if (yc_mode && thr_active[0]) begin
            state_d.err = 1'b1;
        end
        odd_err = state_q.err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/cdr_req_ctrl.sv
module cdr_req_ctrl #(
    parameter int THR_W = 10,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thr,
    input  logic             dw_wr,
    input  logic             dma_rd,
    input  logic             field_start,
    output logic             dma_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             evt;
    } req_state_t;

    req_state_t       state_d, state_q;
    logic             fire;
    logic [CNT_W-1:0] thr_ext;
    logic [CNT_W-1:0] base;

    always_comb begin
        state_d = state_q;
        thr_ext = CNT_W'(thr);
        fire    = state_q.armed && (thr != '0) && (state_q.cnt >= thr_ext);
        base    = fire ? (state_q.cnt - thr_ext) : state_q.cnt;

        if (field_start) begin
            state_d.cnt = {{(CNT_W-1){1'b0}}, dw_wr};
        end else if (dw_wr && (base != CNT_MAX)) begin
            state_d.cnt = base + 1'b1;
        end else begin
            state_d.cnt = base;
        end

        if (fire) begin
            state_d.armed = 1'b0;
        end else if (!state_q.armed && dma_rd) begin
            state_d.armed = 1'b1;
        end

        state_d.evt = fire;
        dma_evt     = state_q.evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.armed <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/capture_dma_req.sv
module capture_dma_req
    import cdr_pkg::*;
#(
    parameter int THR_W  = 10,
    parameter int F2_LSB = 16,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [1:0]        mode,
    input  logic              field,
    input  logic              f2_en,
    input  logic              field_start,
    input  logic              dw_wr,
    input  logic              dma_rd,
    output logic              dma_evt,
    output logic [THR_W-1:0]  thr_active,
    output logic [THR_W-1:0]  chroma_thr,
    output logic              odd_err
);

    cdr_thr_regs #(
        .THR_W  (THR_W),
        .F2_LSB (F2_LSB)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .mode       (mode),
        .field      (field),
        .f2_en      (f2_en),
        .cfg_rdata  (cfg_rdata),
        .thr_active (thr_active),
        .chroma_thr (chroma_thr),
        .odd_err    (odd_err)
    );

    cdr_req_ctrl #(
        .THR_W (THR_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr         (thr_active),
        .dw_wr       (dw_wr),
        .dma_rd      (dma_rd),
        .field_start (field_start),
        .dma_evt     (dma_evt)
    );

endmodule

// File: rtl/cdr_checker.sv
module cdr_checker #(
    parameter int THR_W  = 10,
    parameter int F2_LSB = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      cfg_rdata,
    input logic [1:0]       mode,
    input logic             field,
    input logic             f2_en,
    input logic             dma_rd,
    input logic             dma_evt,
    input logic [THR_W-1:0] thr_active,
    input logic [THR_W-1:0] chroma_thr,
    input logic             odd_err
);

    logic             blk_q;
    logic [THR_W-1:0] f1_rd;
    logic [THR_W-1:0] f2_rd;

    assign f1_rd = cfg_rdata[THR_W-1:0];
    assign f2_rd = cfg_rdata[F2_LSB +: THR_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= 1'b0;
        end else if (dma_rd) begin
            blk_q <= 1'b0;
        end else if (dma_evt) begin
            blk_q <= 1'b1;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[31:F2_LSB+THR_W] == '0) && (cfg_rdata[F2_LSB-1:THR_W] == '0)); // R2

    AST_F1_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != 2'd0) || !field || !f2_en) |-> (thr_active == f1_rd)); // R3

    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_evt |=> !dma_evt); // R4

    AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        blk_q |-> !dma_evt); // R5

    AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((f1_rd == '0) && (f2_rd == '0)) |=> !dma_evt); // R7

    AST_CHROMA_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0) |-> (chroma_thr == '0)); // R9

    AST_ODD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd0) && thr_active[0]) |=> odd_err); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        odd_err |=> odd_err); // R10

endmodule

bind capture_dma_req cdr_checker #(
    .THR_W  (THR_W),
    .F2_LSB (F2_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .mode       (mode),
    .field      (field),
    .f2_en      (f2_en),
    .dma_rd     (dma_rd),
    .dma_evt    (dma_evt),
    .thr_active (thr_active),
    .chroma_thr (chroma_thr),
    .odd_err    (odd_err)
);

// File: tb/capture_dma_req_tb.sv
`timescale 1ns/1ps
module capture_dma_req_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  mode = 2'd0;
    logic        field = 1'b0;
    logic        f2_en = 1'b0;
    logic        field_start = 1'b0;
    logic        dw_wr = 1'b0;
    logic        dma_rd = 1'b0;
    logic        dma_evt;
    logic [9:0]  thr_active;
    logic [9:0]  chroma_thr;
    logic        odd_err;

    int n_chk = 0;
    int n_fail = 0;
    int evt_cnt = 0;
    int cyc = 0;
    int base_cnt;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    capture_dma_req u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .mode        (mode),
        .field       (field),
        .f2_en       (f2_en),
        .field_start (field_start),
        .dw_wr       (dw_wr),
        .dma_rd      (dma_rd),
        .dma_evt     (dma_evt),
        .thr_active  (thr_active),
        .chroma_thr  (chroma_thr),
        .odd_err     (odd_err)
    );

    // {wdata, mode, field, f2_en, exp_rdata, exp_thr, exp_chroma}
    localparam logic [87:0] VEC [9] = '{
        {32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0, 32'h03FF_03FF, 10'h3FF, 10'h1FF},
        {32'h0123_0040, 2'd0, 1'b1, 1'b1, 32'h0123_0040, 10'h123, 10'h091},
        {32'h0123_0040, 2'd0, 1'b1, 1'b0, 32'h0123_0040, 10'h040, 10'h020},
        {32'h0123_0040, 2'd0, 1'b0, 1'b1, 32'h0123_0040, 10'h040, 10'h020},
        {32'h0123_0040, 2'd1, 1'b1, 1'b1, 32'h0123_0040, 10'h040, 10'h000},
        {32'h0123_0040, 2'd2, 1'b1, 1'b1, 32'h0123_0040, 10'h040, 10'h000},
        {32'h0123_0040, 2'd3, 1'b1, 1'b1, 32'h0123_0040, 10'h040, 10'h000},
        {32'hFC00_FC00, 2'd0, 1'b0, 1'b0, 32'h0000_0000, 10'h000, 10'h000},
        {32'h0284_0101, 2'd0, 1'b1, 1'b1, 32'h0284_0101, 10'h284, 10'h142}
    };

    always @(negedge clk) if (rst_n && dma_evt) evt_cnt++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; mode = 2'd0; field = 1'b0;
        f2_en = 1'b0; field_start = 1'b0; dw_wr = 1'b0; dma_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [31:0] data);
        cfg_wr = 1'b1; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            dw_wr = 1'b1;
            @(negedge clk);
        end
        dw_wr = 1'b0;
    endtask

    task automatic rd_pulse();
        dma_rd = 1'b1;
        @(negedge clk);
        dma_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        do_reset();
        chk("R1 rdata", cfg_rdata, 32'h0);
        chk("R1 dma_evt", {31'h0, dma_evt}, 32'h0);
        chk("R1 odd_err", {31'h0, odd_err}, 32'h0);
        chk("R1 thr_active", {22'h0, thr_active}, 32'h0);
        chk("R1 chroma_thr", {22'h0, chroma_thr}, 32'h0);

        // R2 R3 R9: table walk
        for (int v = 0; v < 9; v++) begin
            mode  = VEC[v][55:54];
            field = VEC[v][53];
            f2_en = VEC[v][52];
            wr_reg(VEC[v][87:56]);
            chk("R2 rdata", cfg_rdata, VEC[v][51:20]);
            chk("R3 thr_active", {22'h0, thr_active}, {22'h0, VEC[v][19:10]});
            chk("R9 chroma_thr", {22'h0, chroma_thr}, {22'h0, VEC[v][9:0]});
        end

        // R4: exact event timing
        do_reset();
        mode = 2'd1;
        wr_reg(32'h0000_0004);
        push(3);
        chk("R4 no early evt", {31'h0, dma_evt}, 32'h0);
        dw_wr = 1'b1;
        @(negedge clk);
        dw_wr = 1'b0;
        chk("R4 evt not yet", {31'h0, dma_evt}, 32'h0);
        @(negedge clk);
        chk("R4 evt high", {31'h0, dma_evt}, 32'h1);
        @(negedge clk);
        chk("R4 evt one cycle", {31'h0, dma_evt}, 32'h0);

        // R5 R6: blocking and carry
        base_cnt = evt_cnt;
        push(8);
        idle(4);
        chk("R5 blocked", evt_cnt - base_cnt, 0);
        rd_pulse();
        idle(3);
        chk("R5 re-armed by read", evt_cnt - base_cnt, 1);
        rd_pulse();
        idle(3);
        chk("R6 carried count", evt_cnt - base_cnt, 2);
        rd_pulse();
        idle(3);
        chk("R6 count drained", evt_cnt - base_cnt, 2);

        // R7: zero threshold
        wr_reg(32'h0);
        push(10);
        rd_pulse();
        idle(3);
        chk("R7 zero threshold", evt_cnt - base_cnt, 2);

        // R8: field start clears the count
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
        wr_reg(32'h0000_0004);
        push(3);
        field_start = 1'b1; dw_wr = 1'b1;
        @(negedge clk);
        field_start = 1'b0; dw_wr = 1'b0;
        push(2);
        idle(3);
        chk("R8 cleared at field start", evt_cnt - base_cnt, 2);
        push(1);
        idle(3);
        chk("R8 concurrent write counted", evt_cnt - base_cnt, 3);

        // R11: saturation
        do_reset();
        mode = 2'd1;
        push(4200);
        base_cnt = evt_cnt;
        wr_reg(32'h0000_03E8);
        idle(3);
        for (int k = 0; k < 6; k++) begin
            rd_pulse();
            idle(4);
        end
        chk("R11 events from saturated count", evt_cnt - base_cnt, 4);
        push(905);
        idle(3);
        chk("R11 remainder kept", evt_cnt - base_cnt, 5);

        // R10: odd threshold flag
        do_reset();
        mode = 2'd1;
        wr_reg(32'h0000_0003);
        idle(2);
        chk("R10 no flag in raw mode", {31'h0, odd_err}, 32'h0);
        mode = 2'd0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 flag set", {31'h0, odd_err}, 32'h1);
        chk("R9 odd rounds down", {22'h0, chroma_thr}, 32'h1);
        wr_reg(32'h0000_0004);
        idle(2);
        chk("R10 flag sticky", {31'h0, odd_err}, 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule